// File: doc/BRIEF.md
# System Control Register Block

This block is the register file of a small processor's system control space. Software reaches it through a single-cycle synchronous bus port with a byte offset, and it drives the control state that the rest of the core uses. That state covers the pending flags of three system exceptions, a system reset request, the sleep configuration, the vector table base and three handler priorities. It also reports status the core feeds in: the active and pending exception numbers, whether an external interrupt is pending, and whether a supervisor call is pending. Debug event pulses are captured into sticky flags that software clears.

The pending flags for the PendSV and SysTick exceptions each have a write-1 set bit and a write-1 clear bit. The NMI flag has only a set bit. Every pending flag reads back its live state. The core's exception logic clears a flag through a per-exception acknowledge input. Whenever a set and a clear meet in the same cycle, the set wins. The reset control register accepts a write only when the write carries the correct key. Exception prioritisation and vectoring are done elsewhere.

Read data is registered: a read issued in cycle t appears on `bus_rdata` after the clock edge that ends cycle t. It holds the state before any update made in that same cycle. `bus_rdata` is zero in every cycle that does not follow a read.

Top module: `sysctl_regs`

## Requirements
- R1: After a synchronous reset, every pending flag, debug flag, the reset request, the sleep outputs, the vector base and all priorities are zero.
- R2: A write to offset 0xD04 with bit 28 set makes PendSV pending, and bit 27 set clears it. Bit 26 set makes SysTick pending, and bit 25 set clears it. Zero bits have no effect. Reads return PendSV pending at bit 28 and SysTick pending at bit 26, and `pend_o` is {NMI, SysTick, PendSV}.
- R3: Writing bit 31 of 0xD04 makes NMI pending, and reads return that state at bit 31. No software write clears NMI.
- R4: `exc_ack[i]` clears pending flag i (0 PendSV, 1 SysTick, 2 NMI). A software set in the same cycle as a clear, whether the clear comes from an acknowledge or from software, leaves the flag set.
- R5: Reads of 0xD04 return `act_exc` in bits 8:0, `pend_exc` in bits 20:12 and `ext_irq_pend` at bit 22. Writes do not change these fields.
- R6: Offset 0xD08 stores bits 31:7 of the vector table base. Bits 6:0 read as zero, and `vtor_base` carries the stored value.
- R7: A write to 0xD0C takes effect only when bits 31:16 equal 0x05FA. With that key, bit 2 set raises `sys_reset_req`, which then stays high until reset. Reads of 0xD0C return 0xFA05 in bits 31:16, the endianness parameter at bit 15 and the request at bit 2.
- R8: Offset 0xD10 holds sleep-on-exit at bit 1, deep-sleep at bit 2 and send-event-on-pending at bit 4. These drive `sleep_on_exit`, `sleep_deep` and `sev_on_pend`.
- R9: Offset 0xD00 reads the ID parameter. Offset 0xD14 reads the unaligned-trap parameter at bit 3 and the 8-byte stack alignment parameter at bit 9. Writes to either offset are ignored.
- R10: Offset 0xD1C bits 31:24 hold the SVCall priority. Offset 0xD20 bits 23:16 hold the PendSV priority and bits 31:24 the SysTick priority. Only the top PRI_BITS bits of each priority (default 2) are stored, and the lower bits read as zero.
- R11: Offset 0xD24 bit 15 reads `svc_pend`, and every other bit reads zero.
- R12: At offset 0xD30, bits 4:0 are sticky flags set by `dbg_evt[4:0]` (halt, breakpoint, watchpoint, vector catch, external request). Writing 1 to a bit clears it. An event arriving in the same cycle as the clear leaves the flag set.
- R13: Reads of unmapped offsets (for example 0xD18 and 0xD2C) return zero, and writes to them change nothing. Read data appears one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Word-aligned byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| act_exc | input | 9 | Active exception number |
| pend_exc | input | 9 | Highest pending enabled exception number |
| ext_irq_pend | input | 1 | External interrupt pending |
| svc_pend | input | 1 | Supervisor call pending |
| exc_ack | input | 3 | Handler clear of pending flags {NMI, SysTick, PendSV} |
| dbg_evt | input | 5 | Debug event pulses |
| pend_o | output | 3 | Pending flags {NMI, SysTick, PendSV} |
| sys_reset_req | output | 1 | System reset request |
| sleep_on_exit | output | 1 | Sleep on return to thread mode |
| sleep_deep | output | 1 | Deep sleep select |
| sev_on_pend | output | 1 | Any pending interrupt wakes |
| vtor_base | output | 32 | Vector table base |
| pri_svc | output | 8 | SVCall priority |
| pri_pendsv | output | 8 | PendSV priority |
| pri_systick | output | 8 | SysTick priority |

## Verification
The assertions assume word-aligned offsets on `bus_addr` and a known value on every input after reset. They also assume that a clear from `exc_ack` or a write-1 clear may meet a set in any cycle. The stimulus only ever drives offsets from a fixed list of aligned words, with a few unmapped ones mixed in. Acknowledges and debug pulses are drawn at random and sparsely, so they often land in the same cycle as bus writes to the same bits. Directed steps force each such collision at least once.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [11:0] OFS_ID    = 12'hD00;
  localparam logic [11:0] OFS_ICSR  = 12'hD04;
  localparam logic [11:0] OFS_VTAB  = 12'hD08;
  localparam logic [11:0] OFS_RSTC  = 12'hD0C;
  localparam logic [11:0] OFS_SLP   = 12'hD10;
  localparam logic [11:0] OFS_CFG   = 12'hD14;
  localparam logic [11:0] OFS_PRIA  = 12'hD1C;
  localparam logic [11:0] OFS_PRIB  = 12'hD20;
  localparam logic [11:0] OFS_HSTAT = 12'hD24;
  localparam logic [11:0] OFS_DBG   = 12'hD30;

  localparam logic [15:0] KEY_WRITE = 16'h05FA;
  localparam logic [15:0] KEY_READ  = 16'hFA05;

  // pending flag indices
  typedef enum logic [1:0] {
    PND_PENDSV  = 2'd0,
    PND_SYSTICK = 2'd1,
    PND_NMI     = 2'd2
  } pend_idx_e;

  localparam int NUM_PEND = 3;
  localparam int NUM_DBG  = 5;
  localparam int NUM_PRI  = 3;
endpackage

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;

    // R4 / R12: a set always wins over a clear in the same cycle
    a_r4_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_o[i]);
    a_r12_clear_only: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
  end
endmodule

// File: rtl/sysctl_prio.sv
module sysctl_prio #(
  parameter int NUM      = 3,
  parameter int PRI_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM-1:0]      we_i,
  input  logic [NUM-1:0][7:0] wbyte_i,
  output logic [NUM-1:0][7:0] pri_o
);
  localparam int LOW = 8 - PRI_BITS;

  for (genvar k = 0; k < NUM; k++) begin : g_pri
    logic [PRI_BITS-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (we_i[k]) q <= wbyte_i[k][7 -: PRI_BITS];
    end
    assign pri_o[k] = 8'(q) << LOW;

    a_r10_top_bits_kept: assert property (@(posedge clk) disable iff (rst)
      we_i[k] |=> pri_o[k][7 -: PRI_BITS] == $past(wbyte_i[k][7 -: PRI_BITS]));
    a_r10_stable_no_write: assert property (@(posedge clk) disable iff (rst)
      !we_i[k] |=> $stable(pri_o[k]));
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          EXC_W      = 9,
  parameter int          PRI_BITS   = 2,
  parameter logic [31:0] ID_WORD    = 32'h0A15_0C01,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter bit          UNALIGN_TRAP = 1'b0,
  parameter bit          STACK_8B   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EXC_W-1:0]  act_exc,
  input  logic [EXC_W-1:0]  pend_exc,
  input  logic              ext_irq_pend,
  input  logic              svc_pend,
  input  logic [2:0]        exc_ack,
  input  logic [4:0]        dbg_evt,
  output logic [2:0]        pend_o,
  output logic              sys_reset_req,
  output logic              sleep_on_exit,
  output logic              sleep_deep,
  output logic              sev_on_pend,
  output logic [31:0]       vtor_base,
  output logic [7:0]        pri_svc,
  output logic [7:0]        pri_pendsv,
  output logic [7:0]        pri_systick
);
  localparam int VT_LSB = 7;
  localparam int VT_W   = 32 - VT_LSB;

  logic wr_en, rd_en;
  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  logic hit_icsr, hit_vtab, hit_rstc, hit_slp, hit_pria, hit_prib, hit_dbg;
  assign hit_icsr = wr_en && (bus_addr == OFS_ICSR);
  assign hit_vtab = wr_en && (bus_addr == OFS_VTAB);
  assign hit_rstc = wr_en && (bus_addr == OFS_RSTC);
  assign hit_slp  = wr_en && (bus_addr == OFS_SLP);
  assign hit_pria = wr_en && (bus_addr == OFS_PRIA);
  assign hit_prib = wr_en && (bus_addr == OFS_PRIB);
  assign hit_dbg  = wr_en && (bus_addr == OFS_DBG);

  logic key_ok;
  assign key_ok = (bus_wdata[31:16] == KEY_WRITE);

  // pending flags: set by software, cleared by software or handler ack
  logic [NUM_PEND-1:0] pnd_set, pnd_clr, pnd_q;
  always_comb begin
    pnd_set = '0;
    pnd_clr = exc_ack;
    if (hit_icsr) begin
      pnd_set[PND_PENDSV]  = bus_wdata[28];
      pnd_set[PND_SYSTICK] = bus_wdata[26];
      pnd_set[PND_NMI]     = bus_wdata[31];
      pnd_clr[PND_PENDSV]  = exc_ack[PND_PENDSV]  | bus_wdata[27];
      pnd_clr[PND_SYSTICK] = exc_ack[PND_SYSTICK] | bus_wdata[25];
    end
  end

  sysctl_setclr #(.N(NUM_PEND)) u_pend (
    .clk(clk), .rst(rst), .set_i(pnd_set), .clr_i(pnd_clr), .flag_o(pnd_q)
  );
  assign pend_o = pnd_q;

  // sticky debug event flags, write-1 clear
  logic [NUM_DBG-1:0] dbg_clr, dbg_q;
  assign dbg_clr = hit_dbg ? bus_wdata[NUM_DBG-1:0] : '0;

  sysctl_setclr #(.N(NUM_DBG)) u_dbg (
    .clk(clk), .rst(rst), .set_i(dbg_evt), .clr_i(dbg_clr), .flag_o(dbg_q)
  );

  // handler priorities
  logic [NUM_PRI-1:0]      pri_we;
  logic [NUM_PRI-1:0][7:0] pri_wb, pri_q;
  assign pri_we = {hit_prib, hit_prib, hit_pria};
  assign pri_wb = {bus_wdata[31:24], bus_wdata[23:16], bus_wdata[31:24]};

  sysctl_prio #(.NUM(NUM_PRI), .PRI_BITS(PRI_BITS)) u_prio (
    .clk(clk), .rst(rst), .we_i(pri_we), .wbyte_i(pri_wb), .pri_o(pri_q)
  );
  assign pri_svc     = pri_q[0];
  assign pri_pendsv  = pri_q[1];
  assign pri_systick = pri_q[2];

  // plain control registers
  logic [VT_W-1:0] vt_q;
  logic            rreq_q;
  logic [2:0]      slp_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      vt_q   <= '0;
      rreq_q <= 1'b0;
      slp_q  <= '0;
    end else begin
      if (hit_vtab)                             vt_q  <= bus_wdata[31:VT_LSB];
      if (hit_rstc && key_ok && bus_wdata[2])   rreq_q <= 1'b1;
      if (hit_slp) slp_q <= {bus_wdata[4], bus_wdata[2], bus_wdata[1]};
    end
  end
  assign vtor_base     = {vt_q, {VT_LSB{1'b0}}};
  assign sys_reset_req = rreq_q;
  assign sleep_on_exit = slp_q[0];
  assign sleep_deep    = slp_q[1];
  assign sev_on_pend   = slp_q[2];

  // read decode
  logic [31:0] rd_word;
  logic        mapped;
  always_comb begin
    rd_word = '0;
    mapped  = 1'b1;
    case (bus_addr)
      OFS_ID:   rd_word = ID_WORD;
      OFS_ICSR: begin
        rd_word[EXC_W-1:0]       = act_exc;
        rd_word[12 +: EXC_W]     = pend_exc;
        rd_word[22]              = ext_irq_pend;
        rd_word[26]              = pnd_q[PND_SYSTICK];
        rd_word[28]              = pnd_q[PND_PENDSV];
        rd_word[31]              = pnd_q[PND_NMI];
      end
      OFS_VTAB: rd_word = vtor_base;
      OFS_RSTC: begin
        rd_word[31:16] = KEY_READ;
        rd_word[15]    = BIG_ENDIAN;
        rd_word[2]     = rreq_q;
      end
      OFS_SLP: begin
        rd_word[1] = slp_q[0];
        rd_word[2] = slp_q[1];
        rd_word[4] = slp_q[2];
      end
      OFS_CFG: begin
        rd_word[3] = UNALIGN_TRAP;
        rd_word[9] = STACK_8B;
      end
      OFS_PRIA:  rd_word[31:24] = pri_q[0];
      OFS_PRIB:  rd_word = {pri_q[2], pri_q[1], 16'h0000};
      OFS_HSTAT: rd_word[15] = svc_pend;
      OFS_DBG:   rd_word[NUM_DBG-1:0] = dbg_q;
      default:   mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_en ? rd_word : '0;
  end

  // R7: a write with a wrong key leaves the request untouched
  a_r7_bad_key_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == OFS_RSTC && bus_wdata[31:16] != KEY_WRITE)
      |=> $stable(sys_reset_req));
  // R7: once raised, the request holds until reset
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> sys_reset_req);
  // R13: unmapped reads return zero on the next cycle
  a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> bus_rdata == 32'h0);
  // R13: idle cycles leave zero read data
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> bus_rdata == 32'h0);
  // R6: the vector base moves only on a write to its offset
  a_r6_vtor_stable: assert property (@(posedge clk) disable iff (rst)
    !hit_vtab |=> $stable(vtor_base));
endmodule

// File: tb/sysctl_regs_bench.sv
`timescale 1ns/1ps
module sysctl_regs_bench;
  localparam logic [31:0] ID_EXP   = 32'h0A15_0C01;
  localparam logic [7:0]  PRI_MASK = 8'hC0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  act_exc = '0, pend_exc = '0;
  logic        ext_irq_pend = 1'b0, svc_pend = 1'b0;
  logic [2:0]  exc_ack = '0;
  logic [4:0]  dbg_evt = '0;
  logic [2:0]  pend_o;
  logic        sys_reset_req, sleep_on_exit, sleep_deep, sev_on_pend;
  logic [31:0] vtor_base;
  logic [7:0]  pri_svc, pri_pendsv, pri_systick;

  always #10 clk = ~clk;

  sysctl_regs u_sysctl_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .act_exc(act_exc), .pend_exc(pend_exc), .ext_irq_pend(ext_irq_pend),
    .svc_pend(svc_pend), .exc_ack(exc_ack), .dbg_evt(dbg_evt),
    .pend_o(pend_o), .sys_reset_req(sys_reset_req),
    .sleep_on_exit(sleep_on_exit), .sleep_deep(sleep_deep),
    .sev_on_pend(sev_on_pend), .vtor_base(vtor_base),
    .pri_svc(pri_svc), .pri_pendsv(pri_pendsv), .pri_systick(pri_systick)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference model state
  logic [2:0]  m_pnd;   // {NMI, SysTick, PendSV}
  logic [4:0]  m_dbg;
  logic [31:0] m_vt;
  logic        m_rreq;
  logic [2:0]  m_slp;   // {sev, deep, on_exit}
  logic [7:0]  m_pri [3];

  task automatic model_reset();
    m_pnd = '0; m_dbg = '0; m_vt = '0; m_rreq = 1'b0; m_slp = '0;
    for (int k = 0; k < 3; k++) m_pri[k] = '0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'hD00, 12'hD14: return "R9 read";
      12'hD04: return "R2 R3 R5 read";
      12'hD08: return "R6 read";
      12'hD0C: return "R7 read";
      12'hD10: return "R8 read";
      12'hD1C, 12'hD20: return "R10 read";
      12'hD24: return "R11 read";
      12'hD30: return "R12 read";
      default: return "R13 read";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [31:0] r = '0;
    case (a)
      12'hD00: r = ID_EXP;
      12'hD04: begin
        r[8:0] = act_exc; r[20:12] = pend_exc; r[22] = ext_irq_pend;
        r[26] = m_pnd[1]; r[28] = m_pnd[0]; r[31] = m_pnd[2];
      end
      12'hD08: r = m_vt;
      12'hD0C: begin r[31:16] = 16'hFA05; r[2] = m_rreq; end
      12'hD10: begin r[1] = m_slp[0]; r[2] = m_slp[1]; r[4] = m_slp[2]; end
      12'hD14: r[9] = 1'b1;
      12'hD1C: r[31:24] = m_pri[0];
      12'hD20: begin r[23:16] = m_pri[1]; r[31:24] = m_pri[2]; end
      12'hD24: r[15] = svc_pend;
      12'hD30: r[4:0] = m_dbg;
      default: r = '0;
    endcase
    return r;
  endfunction

  // one bus cycle starting at a falling edge; checks after the next falling edge
  task automatic step(bit sel, bit wr, logic [11:0] a, logic [31:0] d,
                      logic [2:0] ack, logic [4:0] evt);
    logic [31:0] exp_rd;
    logic [2:0]  st, cl;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    exc_ack = ack; dbg_evt = evt;
    exp_rd = (sel && !wr) ? exp_read(a) : 32'h0;
    st = '0; cl = ack;
    if (sel && wr) begin
      case (a)
        12'hD04: begin
          st = {d[31], d[26], d[28]};
          cl = ack | {1'b0, d[25], d[27]};
        end
        12'hD08: m_vt = {d[31:7], 7'b0};
        12'hD0C: if (d[31:16] == 16'h05FA && d[2]) m_rreq = 1'b1;
        12'hD10: m_slp = {d[4], d[2], d[1]};
        12'hD1C: m_pri[0] = d[31:24] & PRI_MASK;
        12'hD20: begin m_pri[1] = d[23:16] & PRI_MASK; m_pri[2] = d[31:24] & PRI_MASK; end
        12'hD30: m_dbg = m_dbg & ~d[4:0];
        default: ;
      endcase
    end
    m_pnd = (m_pnd & ~cl) | st;
    m_dbg = m_dbg | evt;
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(a), bus_rdata, exp_rd);
    chk("R2 R3 R4 pend_o", {29'b0, pend_o}, {29'b0, m_pnd});
    chk("R7 sys_reset_req", {31'b0, sys_reset_req}, {31'b0, m_rreq});
    chk("R8 sleep outputs", {29'b0, sev_on_pend, sleep_deep, sleep_on_exit}, {29'b0, m_slp});
    chk("R6 vtor_base", vtor_base, m_vt);
    chk("R10 priorities", {8'b0, pri_systick, pri_pendsv, pri_svc},
        {8'b0, m_pri[2], m_pri[1], m_pri[0]});
  endtask

  task automatic rd(logic [11:0] a);
    step(1'b1, 1'b0, a, 32'h0, 3'b0, 5'b0);
  endtask
  task automatic wr(logic [11:0] a, logic [31:0] d);
    step(1'b1, 1'b1, a, d, 3'b0, 5'b0);
  endtask

  localparam logic [11:0] ADDRS [12] = '{12'hD00, 12'hD04, 12'hD08, 12'hD0C,
    12'hD10, 12'hD14, 12'hD1C, 12'hD20, 12'hD24, 12'hD30, 12'hD18, 12'hD2C};

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen through every mapped offset and the outputs
    for (int i = 0; i < 12; i++) rd(ADDRS[i]);

    // R9: read-only words ignore writes
    wr(12'hD00, 32'hFFFF_FFFF); rd(12'hD00);
    wr(12'hD14, 32'hFFFF_FFFF); rd(12'hD14);
    // R5: status inputs reflected
    act_exc = 9'h1A5; pend_exc = 9'h0F3; ext_irq_pend = 1'b1;
    rd(12'hD04);
    // R2: set and clear both written in one write: set wins
    wr(12'hD04, 32'h1800_0000); rd(12'hD04);
    wr(12'hD04, 32'h0800_0000); rd(12'hD04);
    wr(12'hD04, 32'h0400_0000); wr(12'hD04, 32'h0000_0000); rd(12'hD04);
    // R3: NMI set, no software clear
    wr(12'hD04, 32'h8000_0000); wr(12'hD04, 32'h0A00_0000); rd(12'hD04);
    // R4: handler ack meets software set in the same cycle
    step(1'b1, 1'b1, 12'hD04, 32'h9000_0000, 3'b101, 5'b0);
    step(1'b0, 1'b0, 12'h000, 32'h0, 3'b111, 5'b0);
    // R6: low vector bits dropped
    wr(12'hD08, 32'hDEAD_BEFF); rd(12'hD08);
    // R7: wrong key ignored, right key raises the request
    wr(12'hD0C, 32'h05FB_0004); rd(12'hD0C);
    wr(12'hD0C, 32'h05FA_0004); rd(12'hD0C);
    wr(12'hD0C, 32'h05FA_0000); rd(12'hD0C);
    // R8, R10, R11
    wr(12'hD10, 32'hFFFF_FFFF); rd(12'hD10);
    wr(12'hD1C, 32'hFFFF_FFFF); wr(12'hD20, 32'h7F80_FFFF);
    rd(12'hD1C); rd(12'hD20);
    svc_pend = 1'b1; rd(12'hD24);
    // R12: sticky events, w1c, event wins over same-cycle clear
    step(1'b0, 1'b0, 12'h000, 32'h0, 3'b0, 5'b10101);
    step(1'b1, 1'b1, 12'hD30, 32'h0000_001F, 3'b0, 5'b00001);
    rd(12'hD30);
    // R13: unmapped offsets
    wr(12'hD18, 32'hFFFF_FFFF); rd(12'hD18); rd(12'hD2C);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = ADDRS[$urandom_range(0, 11)];
      d = $urandom();
      if (a == 12'hD0C && $urandom_range(0, 1) == 1) d[31:16] = 16'h05FA;
      act_exc = 9'($urandom()); pend_exc = 9'($urandom());
      ext_irq_pend = 1'($urandom()); svc_pend = 1'($urandom());
      step($urandom_range(0, 3) != 0, 1'($urandom()), a, d,
           ($urandom_range(0, 3) == 0) ? 3'($urandom()) : 3'b0,
           ($urandom_range(0, 3) == 0) ? 5'($urandom()) : 5'b0);
    end
    // R1: reset again clears everything
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    rd(12'hD04); rd(12'hD30); rd(12'hD0C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule